// File: doc/BRIEF.md
# Partial-Field Word Load/Store Unit

This block is the field datapath of a machine whose words are sign-magnitude. A word has one sign bit and five bytes of six bits each. A field specifier names a contiguous run of positions, from a left position L to a right position R. Position 0 is the sign, and positions 1 to 5 are the bytes, running from the most significant to the least significant.

For loads, the unit cuts the selected field out of a memory word and builds a full register value from it. The negated load variant inverts the sign of that value. For stores, it merges bytes from a source register into a memory word and returns the updated word. The source can be a full register, a short index register, the jump-address register or the constant plus zero.

Instruction decode, address generation and memory timing are handled elsewhere. The unit takes one request per cycle when `valid_i` is high and registers the result. That result appears one cycle later.

Top module: `field_ldst_unit`

## Requirements
- R1: The field input `fspec_i` holds 8*L + R, so L = `fspec_i[5:3]` and R = `fspec_i[2:0]`. A request is legal only when L <= R, R <= 5 and `op_i` is 0 to 5. The operation codes are: 0 load, 1 negated load, 2 store full register, 3 store index register, 4 store jump-address register, 5 store zero.
- R2: After an illegal request, `err_o` is 1 in the next cycle and `result_o` keeps its previous value. After a legal request, `err_o` is 0.
- R3: On a load, the magnitude of the result holds memory bytes max(L,1) through R, right-justified. All bytes to their left are zero.
- R4: On a load, the result sign is plus (bit 30 = 0) when L > 0. When L = 0, the result sign is the memory sign.
- R5: On a negated load, the sign is the inverse of the R4 sign. It is minus when L > 0 and the opposite of the memory sign when L = 0. The magnitude is the same as in R3.
- R6: On a store, memory byte R receives the rightmost source byte, byte R-1 the one before it, and so on down to byte max(L,1). Every byte outside the field keeps its memory value.
- R7: On a store, the result sign equals the memory sign when L > 0 and the source sign when L = 0.
- R8: An index-register store treats source bytes 1 to 3 as zero and uses the register's sign and its two low bytes.
- R9: A jump-address store uses the register's two low bytes, treats bytes 1 to 3 as zero and always uses a plus sign.
- R10: A store-zero writes plus zero into every selected position and leaves the other positions as they were.
- R11: The result of a request appears on `result_o` one clock after `valid_i`, with `valid_o` high for that one cycle. Reset clears `result_o`, `valid_o` and `err_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (R1) |
| fspec_i | input | 6 | Field specifier 8*L+R |
| mem_i | input | 31 | Memory word, bit 30 sign, byte k at bits [(5-k)*6 +: 6] |
| reg_i | input | 31 | Source register word in the same layout |
| valid_o | output | 1 | Result valid |
| err_o | output | 1 | Illegal request flag |
| result_o | output | 31 | Loaded register value or updated memory word |

## Verification
A fault in the field mask or in the alignment shift shows up in the very next result. It appears either as a byte landing at the wrong position or as a memory byte leaking through outside the field. Sweeping every legal (L:R) pair under each operation exposes such a fault within a single pass.

A fault in sign handling shows in bit 30 one cycle after the request. Sign faults are most visible in pairs where L moves between 0 and 1. A broken hold path for illegal requests shows as a changed result on the cycle that follows the illegal request.

// File: rtl/field_ldst_unit.sv
module field_ldst_unit #(
  parameter int BYTE_W    = 6,
  parameter int NBYTES    = 5,
  parameter int IDX_BYTES = 2,
  localparam int MAG_W    = BYTE_W * NBYTES,
  localparam int WORD_W   = MAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [5:0]        fspec_i,
  input  logic [WORD_W-1:0] mem_i,
  input  logic [WORD_W-1:0] reg_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [WORD_W-1:0] result_o
);
  localparam logic [2:0] OP_LD = 3'd0, OP_LDN = 3'd1, OP_ST = 3'd2,
                         OP_STI = 3'd3, OP_STJ = 3'd4, OP_STZ = 3'd5;
  localparam int IDX_W = IDX_BYTES * BYTE_W;

  logic [2:0] lpos, rpos, lo;
  logic       legal, is_load;
  int         sh;
  logic [MAG_W-1:0] mask, mem_mag, src_mag, ld_mag, st_mag;
  logic             src_sign, ld_sign, st_sign;
  logic [WORD_W-1:0] nxt;

  assign lpos    = fspec_i[5:3];
  assign rpos    = fspec_i[2:0];
  assign lo      = (lpos == 3'd0) ? 3'd1 : lpos;
  assign legal   = (lpos <= rpos) && (int'(rpos) <= NBYTES) && (op_i <= OP_STZ);
  assign is_load = (op_i == OP_LD) || (op_i == OP_LDN);
  assign sh      = legal ? (NBYTES - int'(rpos)) * BYTE_W : 0;
  assign mem_mag = mem_i[MAG_W-1:0];

  always_comb begin
    mask = '0;
    for (int k = 1; k <= NBYTES; k++)
      if (k >= int'(lo) && k <= int'(rpos))
        mask[(NBYTES-k)*BYTE_W +: BYTE_W] = {BYTE_W{1'b1}};
  end

  always_comb begin
    src_sign = reg_i[MAG_W];
    src_mag  = reg_i[MAG_W-1:0];
    case (op_i)
      OP_STI: src_mag = {{(MAG_W-IDX_W){1'b0}}, reg_i[IDX_W-1:0]};
      OP_STJ: begin
        src_sign = 1'b0;
        src_mag  = {{(MAG_W-IDX_W){1'b0}}, reg_i[IDX_W-1:0]};
      end
      OP_STZ: begin
        src_sign = 1'b0;
        src_mag  = '0;
      end
      default: ;
    endcase
  end

  assign ld_mag  = (mem_mag & mask) >> sh;
  assign ld_sign = ((lpos == 3'd0) ? mem_i[MAG_W] : 1'b0) ^ (op_i == OP_LDN);
  assign st_mag  = (mem_mag & ~mask) | ((src_mag << sh) & mask);
  assign st_sign = (lpos == 3'd0) ? src_sign : mem_i[MAG_W];
  assign nxt     = is_load ? {ld_sign, ld_mag} : {st_sign, st_mag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i && !legal;
      if (valid_i && legal) result_o <= nxt;
    end
  end
endmodule

module field_ldst_unit_chk #(
  parameter int WORD_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [5:0]        fspec_i,
  input logic [WORD_W-1:0] mem_i,
  input logic              valid_o,
  input logic              err_o,
  input logic [WORD_W-1:0] result_o
);
  logic ok;
  assign ok = (fspec_i[5:3] <= fspec_i[2:0]) && (fspec_i[2:0] <= 3'd5) && (op_i <= 3'd5);

  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ok) |=> (err_o && $stable(result_o))); // R2
  AST_NO_REQ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && !err_o)); // R11
  AST_LOAD_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ok && op_i == 3'd0 && fspec_i[5:3] != 3'd0) |=> !result_o[WORD_W-1]); // R4
  AST_LOADN_MINUS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ok && op_i == 3'd1 && fspec_i[5:3] != 3'd0) |=> result_o[WORD_W-1]); // R5
  AST_STORE_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ok && op_i >= 3'd2 && fspec_i[5:3] != 3'd0)
    |=> (result_o[WORD_W-1] == $past(mem_i[WORD_W-1]))); // R7
  AST_JUMP_SIGN_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ok && (op_i == 3'd4 || op_i == 3'd5) && fspec_i[5:3] == 3'd0)
    |=> !result_o[WORD_W-1]); // R9
endmodule

bind field_ldst_unit field_ldst_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .fspec_i(fspec_i),
  .mem_i(mem_i), .valid_o(valid_o), .err_o(err_o), .result_o(result_o));

// File: tb/field_ldst_unit_tb.sv
module field_ldst_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [5:0]  fspec_i = '0;
  logic [30:0] mem_i = '0, reg_i = '0;
  logic        valid_o, err_o;
  logic [30:0] result_o;
  int checks = 0, errors = 0;
  logic [30:0] last = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  field_ldst_unit u_dut (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .fspec_i(fspec_i), .mem_i(mem_i), .reg_i(reg_i), .valid_o(valid_o),
    .err_o(err_o), .result_o(result_o));

  function automatic logic [5:0] getb(logic [30:0] w, int k);
    return w[(5-k)*6 +: 6];
  endfunction

  function automatic bit is_legal(logic [2:0] op, int l, int r);
    return (l <= r) && (r <= 5) && (op <= 3'd5);
  endfunction

  // Reference: positionwise copy, R3 R4 R5 for loads, R6 R7 R8 R9 R10 for stores.
  function automatic logic [30:0] model(logic [2:0] op, int l, int r,
                                        logic [30:0] m, logic [30:0] g);
    logic [30:0] out, src;
    int lb = (l == 0) ? 1 : l;
    src = g;
    if (op == 3'd3) src[29:12] = '0;
    if (op == 3'd4) begin src[29:12] = '0; src[30] = 1'b0; end
    if (op == 3'd5) src = '0;
    if (op <= 3'd1) begin
      out = '0;
      for (int i = 0; i < r - lb + 1; i++) out[(5-(5-i))*6 +: 6] = getb(m, r - i);
      out[30] = ((l == 0) ? m[30] : 1'b0) ^ (op == 3'd1);
    end else begin
      out = m;
      for (int i = 0; i < r - lb + 1; i++) out[(5-(r-i))*6 +: 6] = getb(src, 5 - i);
      if (l == 0) out[30] = src[30];
    end
    return out;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R3 R4";
      3'd1: return "R5";
      3'd2: return "R6 R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, int l, int r, logic [30:0] m, logic [30:0] g);
    logic [30:0] exp;
    bit ok = is_legal(op, l, r);
    exp = ok ? model(op, l, r, m, g) : last;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; fspec_i = 6'((l << 3) | r); mem_i = m; reg_i = g;
    @(negedge clk);
    valid_i = 1'b0;
    if (ok) check(tag_of(op), {1'b0, result_o}, {1'b0, exp});
    else    check("R1 R2 hold", {1'b0, result_o}, {1'b0, exp});
    check("R2 flag", {31'd0, err_o}, {31'd0, !ok});
    check("R11 valid", {31'd0, valid_o}, 32'd1);
    last = exp;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    #1;
    // R11 reset state
    check("R11 reset", {result_o, valid_o}, 32'd0);
    check("R11 reset err", {31'd0, err_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    apply(3'd0, 0, 5, 31'h4000_0001, '0);          // R4 full word keeps minus
    apply(3'd1, 0, 0, 31'h4000_0000, '0);          // R5 sign-only, inverted to plus
    apply(3'd1, 1, 5, 31'h0000_0001, '0);          // R5 no sign -> minus
    apply(3'd2, 1, 1, 31'h3FFF_FFFF, 31'h7FFF_FFC5); // R6 rightmost byte lands in byte 1
    apply(3'd4, 0, 2, 31'h7FFF_FFFF, 31'h7FFF_FFFF); // R9 default jump field
    apply(3'd5, 0, 5, 31'h7FFF_FFFF, 31'h1234_5678); // R10 full clear
    apply(3'd0, 3, 2, 31'h1, 31'h2);               // R1 L>R illegal
    apply(3'd2, 0, 6, 31'h1, 31'h2);               // R1 R>5 illegal
    apply(3'd6, 1, 1, 31'h1, 31'h2);               // R1 unknown op
    // R1 sweep: every legal pair under every operation
    for (int op = 0; op < 6; op++)
      for (int l = 0; l <= 5; l++)
        for (int r = l; r <= 5; r++)
          apply(3'(op), l, r, 31'($urandom), 31'($urandom));
    // random mix including illegal requests
    for (int n = 0; n < 400; n++)
      apply(3'($urandom_range(0, 7)), $urandom_range(0, 7), $urandom_range(0, 7),
            31'($urandom), 31'($urandom));
    // R11 idle cycle drops valid
    @(negedge clk);
    check("R11 idle", {30'd0, valid_o, err_o}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule